// File: doc/BRIEF.md
# Flash Reset and Abort Sequencer

This block is the control-side sequencer of a NOR-style flash device. It watches the active-low chip-select, output-enable, write-strobe and hardware-reset pins. It also watches a busy flag and a completion pulse from the internal program/erase engine. From these it decides when the data drivers may turn on, when read data is valid, and when a write strobe may be accepted. When the device is deselected, the outputs go quiet. A long enough low pulse on the reset pin puts the device into reset mode. A reset that arrives while the engine is busy aborts the running operation through a timed shutdown.

On leaving reset, the block does three things in one cycle: it forces the command interface back to array reads, it loads the status register preset, and it locks every block. Read and write wake-up intervals then run before normal access is allowed again. After an aborted operation, both wake-up intervals are counted from the end of the shutdown, not from the rising edge of the reset pin. A sticky flag marks the aborted location as holding invalid data until an operation next completes cleanly. All timing limits are parameters counted in clock cycles. The pins are assumed to be synchronous to the clock.

Top module: `flash_rst_seq`

## Requirements
- R1: While `chip_sel_n` is high, `dq_oe`, `rd_valid` and `wr_accept` are 0 whatever `out_en_n` and `wr_strobe_n` do.
- R2: In normal operation, `dq_oe` and `rd_valid` are 1 in the same cycle that `chip_sel_n` and `out_en_n` are both low. `wr_accept` is 1 in the same cycle that `chip_sel_n` and `wr_strobe_n` are both low. Leaving standby adds no cycle of latency.
- R3: `active_pwr` is 1 whenever `chip_sel_n` is low or `eng_busy` is 1, so it stays 1 through a deselect while the engine is busy.
- R4: With `eng_busy` low, `hw_reset_n` sampled low on T_PLPH consecutive edges sets `reset_mode` from the next cycle on. In reset mode `dq_oe`, `rd_valid` and `wr_accept` are 0. A low pulse of T_PLPH-1 samples changes nothing.
- R5: The first cycle after `hw_reset_n` is sampled high in reset mode is wake cycle 0. Reads (`dq_oe`, `rd_valid`) are enabled from wake cycle T_PHQV on, and writes (`wr_accept`) from wake cycle max(T_PHQV,T_PHWL) on. Before that, strobes have no effect.
- R6: In wake cycle 0, `sts_load`, `lock_all` and `cmd_read_force` pulse high for exactly one cycle, and `sts_value` reads 8'h80.
- R7: `hw_reset_n` sampled low while `eng_busy` is 1 raises `abort_req` from the next cycle on, for exactly T_PLRH cycles, and sets `bad_loc` in the first of them.
- R8: After the last shutdown cycle, the block enters wake cycle 0 if `hw_reset_n` was high in that cycle, and otherwise enters reset mode.
- R9: After an abort, wake cycle 0 is the cycle after the last shutdown cycle, however early `hw_reset_n` rose.
- R10: `bad_loc` stays 1 until an `eng_done` pulse, and it reads 0 from the next cycle.
- R11: After the asynchronous `rst_n`, the block is in normal operation with `bad_loc`, `abort_req`, `reset_mode` and all pulses at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| chip_sel_n | input | 1 | Active-low chip select |
| out_en_n | input | 1 | Active-low output enable |
| wr_strobe_n | input | 1 | Active-low write strobe |
| hw_reset_n | input | 1 | Active-low hardware reset pin |
| eng_busy | input | 1 | Program/erase engine busy |
| eng_done | input | 1 | Pulse: engine finished an operation cleanly |
| dq_oe | output | 1 | Data output buffer enable |
| rd_valid | output | 1 | Read data valid qualifier |
| wr_accept | output | 1 | Write strobe accepted |
| abort_req | output | 1 | Abort request to the engine |
| bad_loc | output | 1 | Aborted location holds invalid data |
| sts_load | output | 1 | Pulse: load status register preset |
| sts_value | output | 8 | Status register preset value |
| lock_all | output | 1 | Pulse: lock every block |
| cmd_read_force | output | 1 | Pulse: return command interface to array reads |
| reset_mode | output | 1 | Device held in reset mode |
| active_pwr | output | 1 | Device draws active power |

## Verification
The access gates are combinational, so `dq_oe`, `rd_valid`, `wr_accept` and `active_pwr` are due in the same cycle the pins change. State effects follow one edge after the sample that causes them: reset mode, the abort start, the shutdown exit and each wake boundary. The driver drives the pins just after each rising edge and queues the values due in that same cycle. The monitor compares them at the falling edge. Every counter limit is checked both one cycle early and in its exact cycle, and the abort case releases the pin early to show that the wake-up count ignores that release.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;
  typedef enum logic [1:0] {
    FS_NORMAL = 2'd0,
    FS_ABORT  = 2'd1,
    FS_RESET  = 2'd2,
    FS_WAKE   = 2'd3
  } frs_state_e;
endpackage

// File: rtl/frs_tmr.sv
module frs_tmr #(
  parameter int LIMIT = 4,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)
      cnt_d = '0;
    else if (run && (cnt != W'(LIMIT)))
      cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/frs_fsm.sv
module frs_fsm
  import flash_rst_pkg::*;
#(
  parameter int T_PLPH = 4,
  parameter int T_PLRH = 6,
  parameter int T_WMAX = 5,
  parameter int T_PHQV = 3,
  localparam int LW = $clog2(T_PLPH + 1),
  localparam int TSPAN = (T_PLRH > T_WMAX) ? T_PLRH : T_WMAX,
  localparam int TW = $clog2(TSPAN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_hi,
  input  logic          busy,
  input  logic [LW-1:0] low_cnt,
  input  logic [TW-1:0] t_cnt,
  output frs_state_e    state_q,
  output logic          t_clr,
  output logic          abort_start,
  output logic          rd_ok,
  output logic          wr_ok,
  output logic          wake_first
);
  frs_state_e state_d;
  logic low_long, shut_last, wake_last;

  assign low_long  = int'(low_cnt) >= T_PLPH - 1;
  assign shut_last = int'(t_cnt) == T_PLRH - 1;
  assign wake_last = int'(t_cnt) == T_WMAX - 1;

  always_comb begin
    state_d = state_q;
    t_clr   = 1'b0;
    unique case (state_q)
      FS_NORMAL: begin
        if (!pin_hi && busy) begin
          state_d = FS_ABORT;
          t_clr   = 1'b1;
        end else if (!pin_hi && low_long) begin
          state_d = FS_RESET;
        end
      end
      FS_ABORT: begin
        if (shut_last) begin
          if (pin_hi) begin
            state_d = FS_WAKE;
            t_clr   = 1'b1;
          end else begin
            state_d = FS_RESET;
          end
        end
      end
      FS_RESET: begin
        if (pin_hi) begin
          state_d = FS_WAKE;
          t_clr   = 1'b1;
        end
      end
      FS_WAKE: begin
        if (!pin_hi)        state_d = FS_RESET;
        else if (wake_last) state_d = FS_NORMAL;
      end
      default: state_d = FS_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FS_NORMAL;
    else        state_q <= state_d;
  end

  assign abort_start = (state_q == FS_NORMAL) && (state_d == FS_ABORT);
  assign rd_ok = (state_q == FS_NORMAL) ||
                 ((state_q == FS_WAKE) && (int'(t_cnt) >= T_PHQV));
  assign wr_ok = (state_q == FS_NORMAL);
  assign wake_first = (state_q == FS_WAKE) && (t_cnt == '0);

  // R7
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_ABORT && int'(t_cnt) < T_PLRH - 1) |=> (state_q == FS_ABORT));

  // R4
  short_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FS_NORMAL && !busy && (pin_hi || !low_long)) |=> (state_q != FS_RESET));
endmodule

// File: rtl/frs_gate.sv
module frs_gate (
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic rd_ok,
  input  logic wr_ok,
  output logic dq_oe,
  output logic rd_valid,
  output logic wr_accept
);
  logic sel;
  assign sel       = !ce_n;
  assign rd_valid  = sel && rd_ok;
  assign dq_oe     = rd_valid && !oe_n;
  assign wr_accept = sel && wr_ok && !we_n;
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
  import flash_rst_pkg::*;
#(
  parameter int          T_PLPH   = 4,
  parameter int          T_PLRH   = 6,
  parameter int          T_PHQV   = 3,
  parameter int          T_PHWL   = 5,
  parameter logic [7:0]  STS_INIT = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_sel_n,
  input  logic       out_en_n,
  input  logic       wr_strobe_n,
  input  logic       hw_reset_n,
  input  logic       eng_busy,
  input  logic       eng_done,
  output logic       dq_oe,
  output logic       rd_valid,
  output logic       wr_accept,
  output logic       abort_req,
  output logic       bad_loc,
  output logic       sts_load,
  output logic [7:0] sts_value,
  output logic       lock_all,
  output logic       cmd_read_force,
  output logic       reset_mode,
  output logic       active_pwr
);
  localparam int T_WMAX = (T_PHQV > T_PHWL) ? T_PHQV : T_PHWL;
  localparam int TSPAN  = (T_PLRH > T_WMAX) ? T_PLRH : T_WMAX;
  localparam int LW     = $clog2(T_PLPH + 1);
  localparam int TW     = $clog2(TSPAN + 1);

  logic [LW-1:0] low_cnt;
  logic [TW-1:0] t_cnt;
  frs_state_e    state_q;
  logic t_clr, abort_start, rd_ok, wr_ok, wake_first;
  logic bad_d, bad_q;

  frs_tmr #(.LIMIT(T_PLPH)) u_low (
    .clk(clk), .rst_n(rst_n), .clr(hw_reset_n), .run(1'b1), .cnt(low_cnt)
  );

  frs_tmr #(.LIMIT(TSPAN)) u_span (
    .clk(clk), .rst_n(rst_n), .clr(t_clr), .run(1'b1), .cnt(t_cnt)
  );

  frs_fsm #(.T_PLPH(T_PLPH), .T_PLRH(T_PLRH), .T_WMAX(T_WMAX), .T_PHQV(T_PHQV)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pin_hi(hw_reset_n), .busy(eng_busy),
    .low_cnt(low_cnt), .t_cnt(t_cnt), .state_q(state_q), .t_clr(t_clr),
    .abort_start(abort_start), .rd_ok(rd_ok), .wr_ok(wr_ok), .wake_first(wake_first)
  );

  frs_gate u_gate (
    .ce_n(chip_sel_n), .oe_n(out_en_n), .we_n(wr_strobe_n),
    .rd_ok(rd_ok), .wr_ok(wr_ok),
    .dq_oe(dq_oe), .rd_valid(rd_valid), .wr_accept(wr_accept)
  );

  always_comb begin
    bad_d = bad_q;
    if (abort_start)   bad_d = 1'b1;
    else if (eng_done) bad_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= bad_d;
  end

  assign bad_loc        = bad_q;
  assign abort_req      = (state_q == FS_ABORT);
  assign reset_mode     = (state_q == FS_RESET);
  assign sts_load       = wake_first;
  assign lock_all       = wake_first;
  assign cmd_read_force = wake_first;
  assign sts_value      = STS_INIT;
  assign active_pwr     = !chip_sel_n || eng_busy;

  // R1
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel_n |-> (!dq_oe && !rd_valid && !wr_accept));

  // R4
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode |-> (!dq_oe && !rd_valid && !wr_accept));

  // R7
  abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_req) |-> bad_loc);

  // R8
  abort_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(abort_req) |-> (reset_mode == !$past(hw_reset_n)));

  // R6
  init_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_load |=> !sts_load);
endmodule

// File: tb/tb_flash_rst_seq.sv
`timescale 1ns/1ps
module tb_flash_rst_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic ce_n, oe_n, we_n, pin, busy, done;
  logic dq_oe, rd_valid, wr_accept, abort_req, bad_loc, sts_load, lock_all;
  logic cmd_read_force, reset_mode, active_pwr;
  logic [7:0] sts_value;

  localparam int S_OE = 0, S_RV = 1, S_WA = 2, S_AB = 3, S_BAD = 4, S_SL = 5;
  localparam int S_LK = 6, S_CRF = 7, S_RM = 8, S_AP = 9, S_SV = 10;

  typedef struct {
    int         cyc;
    int         sel;
    logic [7:0] val;
    string      rq;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  flash_rst_seq dut (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(ce_n), .out_en_n(oe_n),
    .wr_strobe_n(we_n), .hw_reset_n(pin), .eng_busy(busy), .eng_done(done),
    .dq_oe(dq_oe), .rd_valid(rd_valid), .wr_accept(wr_accept),
    .abort_req(abort_req), .bad_loc(bad_loc), .sts_load(sts_load),
    .sts_value(sts_value), .lock_all(lock_all), .cmd_read_force(cmd_read_force),
    .reset_mode(reset_mode), .active_pwr(active_pwr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] observe(int sel);
    case (sel)
      S_OE:    return {7'd0, dq_oe};
      S_RV:    return {7'd0, rd_valid};
      S_WA:    return {7'd0, wr_accept};
      S_AB:    return {7'd0, abort_req};
      S_BAD:   return {7'd0, bad_loc};
      S_SL:    return {7'd0, sts_load};
      S_LK:    return {7'd0, lock_all};
      S_CRF:   return {7'd0, cmd_read_force};
      S_RM:    return {7'd0, reset_mode};
      S_AP:    return {7'd0, active_pwr};
      default: return sts_value;
    endcase
  endfunction

  // monitor: compare everything due in the current cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc == cyc) begin
      exp_t e;
      logic [7:0] got;
      e = q.pop_front();
      got = observe(e.sel);
      total++;
      if (got !== e.val) begin
        bad++;
        $display("FAIL %s sel=%0d cyc=%0d actual=%0h expected=%0h", e.rq, e.sel, cyc, got, e.val);
      end
    end
  end

  task automatic step(input logic c, input logic o, input logic w,
                      input logic p, input logic b, input logic d);
    @(posedge clk);
    #1;
    ce_n = c; oe_n = o; we_n = w; pin = p; busy = b; done = d;
  endtask

  task automatic expect_val(input int sel, input logic [7:0] v, input string rq);
    exp_t e;
    e.cyc = cyc; e.sel = sel; e.val = v; e.rq = rq;
    q.push_back(e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; pin = 1'b1; busy = 1'b0; done = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    step(1, 1, 1, 1, 0, 0);
    expect_val(S_RM, 0, "R11"); expect_val(S_AB, 0, "R11");
    expect_val(S_BAD, 0, "R11"); expect_val(S_SL, 0, "R11");
    expect_val(S_OE, 0, "R11");

    // R1 standby ignores output enable and write strobe
    step(1, 0, 0, 1, 0, 0);
    expect_val(S_OE, 0, "R1"); expect_val(S_RV, 0, "R1");
    expect_val(S_WA, 0, "R1"); expect_val(S_AP, 0, "R3");

    // R2 zero-latency read and write
    step(0, 0, 1, 1, 0, 0);
    expect_val(S_OE, 1, "R2"); expect_val(S_RV, 1, "R2");
    step(0, 1, 0, 1, 0, 0);
    expect_val(S_WA, 1, "R2"); expect_val(S_OE, 0, "R2");

    // R3 active power held by busy engine while deselected
    step(1, 1, 1, 1, 1, 0);
    expect_val(S_AP, 1, "R3"); expect_val(S_OE, 0, "R1");
    step(1, 1, 1, 1, 0, 0);
    expect_val(S_AP, 0, "R3");

    // R4 pulse one sample short is ignored
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0);
    step(0, 0, 1, 1, 0, 0);
    expect_val(S_RM, 0, "R4"); expect_val(S_OE, 1, "R4");
    step(0, 0, 1, 1, 0, 0);
    expect_val(S_RM, 0, "R4"); expect_val(S_OE, 1, "R4");

    // R4 pulse of exactly T_PLPH samples
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 1, 0, 0, 0);
      if (i == 3) begin
        expect_val(S_RM, 0, "R4"); expect_val(S_OE, 1, "R4");
      end
    end
    step(0, 0, 0, 0, 0, 0);
    expect_val(S_RM, 1, "R4"); expect_val(S_OE, 0, "R4");
    expect_val(S_RV, 0, "R4"); expect_val(S_WA, 0, "R4");
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_RM, 1, "R5");
    // wake cycle 0
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_SL, 1, "R6"); expect_val(S_LK, 1, "R6");
    expect_val(S_CRF, 1, "R6"); expect_val(S_SV, 8'h80, "R6");
    expect_val(S_RM, 0, "R5"); expect_val(S_OE, 0, "R5"); expect_val(S_WA, 0, "R5");
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_SL, 0, "R6"); expect_val(S_LK, 0, "R6"); expect_val(S_OE, 0, "R5");
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_OE, 0, "R5"); expect_val(S_RV, 0, "R5");
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_OE, 1, "R5"); expect_val(S_RV, 1, "R5"); expect_val(S_WA, 0, "R5");
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_WA, 0, "R5");
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_WA, 1, "R5");

    // R7/R8/R9 abort with early pin release
    step(0, 0, 1, 0, 1, 0);
    expect_val(S_AB, 0, "R7"); expect_val(S_OE, 1, "R7");
    step(0, 0, 1, 0, 1, 0);
    expect_val(S_AB, 1, "R7"); expect_val(S_BAD, 1, "R7"); expect_val(S_OE, 0, "R7");
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_AB, 1, "R7");
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_OE, 0, "R9");
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_AB, 1, "R7"); expect_val(S_RM, 0, "R8");
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_AB, 0, "R7"); expect_val(S_SL, 1, "R8"); expect_val(S_RM, 0, "R8");
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_OE, 0, "R9");
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_OE, 1, "R9");
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_WA, 0, "R9");
    step(0, 0, 0, 1, 0, 0);
    expect_val(S_WA, 1, "R9"); expect_val(S_BAD, 1, "R10");

    // R10 clean completion clears the flag
    step(1, 1, 1, 1, 0, 1);
    expect_val(S_BAD, 1, "R10");
    step(1, 1, 1, 1, 0, 0);
    expect_val(S_BAD, 0, "R10");

    // R8 abort with pin held past the shutdown
    step(1, 1, 1, 0, 1, 0);
    expect_val(S_AB, 0, "R7");
    step(1, 1, 1, 0, 0, 0);
    expect_val(S_AB, 1, "R7"); expect_val(S_BAD, 1, "R7");
    for (int i = 0; i < 5; i++) step(1, 1, 1, 0, 0, 0);
    expect_val(S_AB, 1, "R8"); expect_val(S_RM, 0, "R8");
    step(1, 1, 1, 0, 0, 0);
    expect_val(S_AB, 0, "R8"); expect_val(S_RM, 1, "R8"); expect_val(S_SL, 0, "R8");
    step(1, 1, 1, 0, 0, 0);
    expect_val(S_RM, 1, "R8");
    step(1, 1, 1, 1, 0, 0);
    expect_val(S_RM, 1, "R8");
    step(1, 1, 1, 1, 0, 0);
    expect_val(S_SL, 1, "R6"); expect_val(S_RM, 0, "R8");
    for (int i = 0; i < 6; i++) step(1, 1, 1, 1, 0, 0);
    step(0, 0, 1, 1, 0, 0);
    expect_val(S_OE, 1, "R2");

    step(1, 1, 1, 1, 0, 0);
    step(1, 1, 1, 1, 0, 0);
    if (q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule